// File: doc/BRIEF.md
# Host Aperture Window Decoder

This block sits between the host bus and planar display memory. Each cycle it takes a 20-bit host memory address and decides whether that address falls inside the aperture picked by a 2-bit window select. If it does, the block produces the offset into display memory and a mask that says which of the four planes take part in the access. A host strobe is passed on as a memory request only on a hit, so an address outside the aperture never reaches the memory.

A chained mode supports the text-style layout where neighbouring bytes live in alternate planes. In that mode the lowest host address bit no longer forms part of the offset. It chooses the even plane pair or the odd plane pair instead, and the offset's lowest bit is filled from the topmost offset bit of the current window. All outputs are registered and appear one clock after the inputs are sampled.

Top module: `gfxWindowDecoder`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it goes high, `hitOut`, `memReq`, `memWrite`, `memOffset` and `planeMask` are all zero.
- R2: With `mapSel` = 0, addresses 0xA0000 through 0xBFFFF hit, and the offset is the address minus 0xA0000.
- R3: With `mapSel` = 1, addresses 0xA0000 through 0xAFFFF hit, and the offset is the address minus 0xA0000.
- R4: With `mapSel` = 2, addresses 0xB0000 through 0xB7FFF hit, and the offset is the address minus 0xB0000.
- R5: With `mapSel` = 3, addresses 0xB8000 through 0xBFFFF hit, and the offset is the address minus 0xB8000.
- R6: An address outside the selected window gives `hitOut` = 0, `memReq` = 0, `memWrite` = 0, `memOffset` = 0 and `planeMask` = 0.
- R7: `memReq` is `hostStrobe` AND hit. `memWrite` is `memReq` AND `hostWrite`.
- R8: With `chainOddEven` = 0, a hit gives `planeMask` = 4'b1111 and leaves the offset unmodified.
- R9: With `chainOddEven` = 1, a hit gives an offset whose bit 0 is replaced by offset bit 16, 15 or 14 (window sizes 128, 64 and 32 KiB). `planeMask` is 4'b1010 (planes 1 and 3) when address bit 0 is 1, and 4'b0101 (planes 0 and 2) when it is 0.
- R10: Outputs change only at a rising clock edge and reflect the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 20 | Host memory address |
| hostStrobe | input | 1 | Host access strobe |
| hostWrite | input | 1 | 1 = write access, 0 = read access |
| mapSel | input | 2 | Aperture window select |
| chainOddEven | input | 1 | Chained odd/even plane addressing enable |
| hitOut | output | 1 | Address lay inside the window |
| memReq | output | 1 | Memory access request |
| memWrite | output | 1 | The request is a write |
| memOffset | output | 17 | Display memory offset |
| planeMask | output | 4 | Planes taking part in the access, bit n = plane n |

## Verification
Two functions can act on the same cycle: the window check and the chained-mode rewrite of the offset and plane mask. Both depend on the same address bits. Randomised addresses are spread around the whole 0xA0000–0xBFFFF range, with both window select and chaining random, so chained accesses at the window edges and just outside them also occur. The bench judges every cycle against a model that applies the window check first and the rewrite only on a hit. A miss must therefore stay fully quiet even when chaining is on and address bit 0 would otherwise choose a plane pair.

// File: rtl/gfx_win_pkg.sv
package gfx_win_pkg;
  parameter int ADDR_W  = 20;
  parameter int OFF_W   = 17;
  parameter int PLANE_N = 4;
  parameter int SEL_W   = 2;

  // strobes from the window control to the offset datapath
  typedef struct packed {
    logic             hit;
    logic             issue;
    logic             isWrite;
    logic             chainOn;
    logic             oddSide;
    logic [SEL_W-1:0] winSel;
  } winCtl_t;

  function automatic logic [ADDR_W-1:0] winBase(input logic [SEL_W-1:0] sel);
    case (sel)
      2'd2:    winBase = ADDR_W'('hB0000);
      2'd3:    winBase = ADDR_W'('hB8000);
      default: winBase = ADDR_W'('hA0000);
    endcase
  endfunction

  // log2 of the window size in bytes
  function automatic int winBits(input logic [SEL_W-1:0] sel);
    case (sel)
      2'd0:    winBits = 17;
      2'd1:    winBits = 16;
      default: winBits = 15;
    endcase
  endfunction
endpackage

// File: rtl/win_decode_ctrl.sv
module win_decode_ctrl
  import gfx_win_pkg::*;
(
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostStrobe,
  input  logic              hostWrite,
  input  logic [SEL_W-1:0]  mapSel,
  input  logic              chainOddEven,
  output winCtl_t           ctl
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] baseExt;
  logic [EXT_W-1:0] limitExt;
  logic [EXT_W-1:0] addrExt;
  logic             inWin;

  always_comb begin
    baseExt  = {1'b0, winBase(mapSel)};
    limitExt = baseExt + (EXT_W'(1) << winBits(mapSel));
    addrExt  = {1'b0, hostAddr};
    inWin    = (addrExt >= baseExt) && (addrExt < limitExt);
  end

  always_comb begin
    ctl.hit     = inWin;
    ctl.issue   = inWin && hostStrobe;
    ctl.isWrite = inWin && hostStrobe && hostWrite;
    ctl.chainOn = chainOddEven;
    ctl.oddSide = hostAddr[0];
    ctl.winSel  = mapSel;
  end
endmodule

// File: rtl/win_offset_path.sv
module win_offset_path
  import gfx_win_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  hostAddr,
  input  winCtl_t            ctl,
  output logic               hitQ,
  output logic               reqQ,
  output logic               wrQ,
  output logic [OFF_W-1:0]   offsetQ,
  output logic [PLANE_N-1:0] maskQ
);
  logic [ADDR_W-1:0]  diff;
  logic [OFF_W-1:0]   rawOff;
  logic [OFF_W-1:0]   nextOff;
  logic [PLANE_N-1:0] nextMask;
  int                 topIdx;

  always_comb begin
    diff    = hostAddr - winBase(ctl.winSel);
    rawOff  = diff[OFF_W-1:0];
    topIdx  = winBits(ctl.winSel) - 1;
    nextOff = rawOff;
    if (ctl.chainOn) nextOff[0] = rawOff[topIdx];
    if (!ctl.hit) nextOff = '0;
  end

  for (genvar p = 0; p < PLANE_N; p++) begin : g_plane
    localparam logic ODD_PLANE = (p % 2) == 1;
    always_comb begin
      if (!ctl.hit)        nextMask[p] = 1'b0;
      else if (ctl.chainOn) nextMask[p] = (ctl.oddSide == ODD_PLANE);
      else                  nextMask[p] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitQ    <= 1'b0;
      reqQ    <= 1'b0;
      wrQ     <= 1'b0;
      offsetQ <= '0;
      maskQ   <= '0;
    end else begin
      hitQ    <= ctl.hit;
      reqQ    <= ctl.issue;
      wrQ     <= ctl.isWrite;
      offsetQ <= nextOff;
      maskQ   <= nextMask;
    end
  end
endmodule

// File: rtl/gfxWindowDecoder.sv
module gfxWindowDecoder
  import gfx_win_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  hostAddr,
  input  logic               hostStrobe,
  input  logic               hostWrite,
  input  logic [SEL_W-1:0]   mapSel,
  input  logic               chainOddEven,
  output logic               hitOut,
  output logic               memReq,
  output logic               memWrite,
  output logic [OFF_W-1:0]   memOffset,
  output logic [PLANE_N-1:0] planeMask
);
  winCtl_t ctl;

  win_decode_ctrl u_ctrl (
    .hostAddr    (hostAddr),
    .hostStrobe  (hostStrobe),
    .hostWrite   (hostWrite),
    .mapSel      (mapSel),
    .chainOddEven(chainOddEven),
    .ctl         (ctl)
  );

  win_offset_path u_path (
    .clk     (clk),
    .rstN    (rstN),
    .hostAddr(hostAddr),
    .ctl     (ctl),
    .hitQ    (hitOut),
    .reqQ    (memReq),
    .wrQ     (memWrite),
    .offsetQ (memOffset),
    .maskQ   (planeMask)
  );
endmodule

// File: rtl/gfxWindowDecoder_chk.sv
module gfxWindowDecoder_chk
  import gfx_win_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  hostAddr,
  input logic               hostStrobe,
  input logic               hostWrite,
  input logic               chainOddEven,
  input logic               hitOut,
  input logic               memReq,
  input logic               memWrite,
  input logic [OFF_W-1:0]   memOffset,
  input logic [PLANE_N-1:0] planeMask
);
  assert_req_needs_hit_R7: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> hitOut);

  assert_write_needs_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> memReq);

  assert_miss_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !hitOut |-> (memOffset == '0 && planeMask == '0 && !memReq));

  assert_hit_in_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    hitOut |-> ($past(hostAddr[19:17]) == 3'b101));

  assert_all_planes_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hitOut && !$past(chainOddEven)) |-> planeMask == 4'hF);

  assert_pair_select_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hitOut && $past(chainOddEven)) |->
      planeMask == ($past(hostAddr[0]) ? 4'hA : 4'h5));

  assert_strobe_follow_R10: assert property (@(posedge clk) disable iff (!rstN)
    (hitOut && $past(rstN)) |-> (memReq == $past(hostStrobe)));
endmodule

bind gfxWindowDecoder gfxWindowDecoder_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .hostAddr    (hostAddr),
  .hostStrobe  (hostStrobe),
  .hostWrite   (hostWrite),
  .chainOddEven(chainOddEven),
  .hitOut      (hitOut),
  .memReq      (memReq),
  .memWrite    (memWrite),
  .memOffset   (memOffset),
  .planeMask   (planeMask)
);

// File: tb/gfxWindowDecoder_test.sv
module gfxWindowDecoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] hostAddr = '0;
  logic        hostStrobe = 1'b0;
  logic        hostWrite = 1'b0;
  logic [1:0]  mapSel = '0;
  logic        chainOddEven = 1'b0;
  logic        hitOut, memReq, memWrite;
  logic [16:0] memOffset;
  logic [3:0]  planeMask;

  int checks = 0;
  int errors = 0;
  logic [26:0] prevExp = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gfxWindowDecoder uut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostStrobe(hostStrobe),
    .hostWrite(hostWrite), .mapSel(mapSel), .chainOddEven(chainOddEven),
    .hitOut(hitOut), .memReq(memReq), .memWrite(memWrite),
    .memOffset(memOffset), .planeMask(planeMask)
  );

  // expected {hit, req, wr, offset[16:0], mask[3:0]} packed into 24 bits (upper bits zero)
  function automatic logic [26:0] model(input logic [19:0] a, input logic s,
                                        input logic w, input logic [1:0] m,
                                        input logic c);
    logic [19:0] base, size, diff;
    logic [16:0] off;
    logic [3:0]  msk;
    int          top;
    logic        hit;
    case (m)
      2'd0: begin base = 20'hA0000; size = 20'h20000; top = 16; end
      2'd1: begin base = 20'hA0000; size = 20'h10000; top = 15; end
      2'd2: begin base = 20'hB0000; size = 20'h08000; top = 14; end
      default: begin base = 20'hB8000; size = 20'h08000; top = 14; end
    endcase
    hit  = (a >= base) && ({1'b0, a} < {1'b0, base} + {1'b0, size});
    diff = a - base;
    off  = diff[16:0];
    if (c) off[0] = diff[top];
    msk  = c ? (a[0] ? 4'b1010 : 4'b0101) : 4'b1111;
    if (!hit) begin off = '0; msk = '0; end
    model = {3'b0, hit, hit & s, hit & s & w, off, msk};
  endfunction

  function automatic logic [26:0] actual();
    actual = {3'b0, hitOut, memReq, memWrite, memOffset, planeMask};
  endfunction

  function automatic string tagFor(input logic [26:0] e, input logic [1:0] m,
                                   input logic c);
    if (!e[23]) return "R6";
    if (c) return "R9";
    case (m)
      2'd0: return "R2/R8";
      2'd1: return "R3/R8";
      2'd2: return "R4/R8";
      default: return "R5/R8";
    endcase
  endfunction

  task automatic compare(input string tag, input logic [26:0] e);
    checks++;
    if (actual() !== e) begin
      errors++;
      $display("FAIL %s: got hit=%0b req=%0b wr=%0b off=%05h mask=%04b, expected hit=%0b req=%0b wr=%0b off=%05h mask=%04b",
               tag, hitOut, memReq, memWrite, memOffset, planeMask,
               e[23], e[22], e[21], e[20:4], e[3:0]);
    end
  endtask

  // drive at negedge; R10: outputs unchanged before the edge; check next negedge
  task automatic apply(input logic [19:0] a, input logic s, input logic w,
                       input logic [1:0] m, input logic c);
    logic [26:0] e;
    @(negedge clk);
    hostAddr = a; hostStrobe = s; hostWrite = w; mapSel = m; chainOddEven = c;
    #1;
    compare("R10", prevExp);
    e = model(a, s, w, m, c);
    @(negedge clk);
    compare(tagFor(e, m, c), e);
    if (s) compare("R7", e);
    prevExp = e;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [19:0] bases [4];
    logic [19:0] sizes [4];
    bases[0] = 20'hA0000; sizes[0] = 20'h20000;
    bases[1] = 20'hA0000; sizes[1] = 20'h10000;
    bases[2] = 20'hB0000; sizes[2] = 20'h08000;
    bases[3] = 20'hB8000; sizes[3] = 20'h08000;
    void'($urandom(32'd4242));

    // R1: reset state, with a hitting access presented during reset
    hostAddr = 20'hA0010; hostStrobe = 1'b1; mapSel = 2'd0;
    repeat (3) @(negedge clk);
    compare("R1", '0);
    rstN = 1'b1;
    hostStrobe = 1'b0; hostAddr = 20'h00000;
    @(negedge clk);
    compare("R1", '0);

    // window edges for each select, both chaining settings
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 2; c++) begin
        apply(bases[m], 1'b1, 1'b0, 2'(m), 1'(c));
        apply(bases[m] + sizes[m] - 20'd1, 1'b1, 1'b1, 2'(m), 1'(c));
        apply(bases[m] - 20'd1, 1'b1, 1'b1, 2'(m), 1'(c));
        apply(bases[m] + sizes[m], 1'b1, 1'b0, 2'(m), 1'(c));
      end
    end

    // R9: explicit top-bit substitution and pair choice
    apply(20'hB0001, 1'b1, 1'b0, 2'd0, 1'b1); // off 10001 -> bit16=1, mask 1010
    apply(20'hA8002, 1'b1, 1'b0, 2'd1, 1'b1); // off 08002 -> bit15=1 -> 08003, 0101
    apply(20'hBC000, 1'b0, 1'b0, 2'd3, 1'b1); // off 04000 -> bit14=1 -> 04001
    // R7: no strobe, no request
    apply(20'hA1234, 1'b0, 1'b1, 2'd0, 1'b0);
    // R6: far outside
    apply(20'h00000, 1'b1, 1'b1, 2'd0, 1'b1);
    apply(20'hFFFFF, 1'b1, 1'b1, 2'd0, 1'b0);

    // randomised traffic around the aperture
    for (int i = 0; i < 600; i++) begin
      logic [19:0] a;
      a = 20'h90000 + 20'($urandom % 32'h40000);
      apply(a, 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule